// File: doc/BRIEF.md
# Buffered UART Transmitter with CTS Flow Control

This block serialises data words onto an asynchronous line. A single holding buffer sits in front of a shift register, so software can queue the next word while the current frame is still going out. Each frame opens with a low start bit and sends 8 or 9 data bits, least significant bit first. An even or odd parity bit may follow, and the frame closes with one or two high stop bits. A bit lasts `OVS × (m + 1)` ticks of a selectable count source. That source can be the core clock, the clock divided by 8, the clock divided by `2n`, or an external tick.

With flow control enabled, a frame does not begin while the clear-to-send input is high. The line then rests at the end of the previous stop bit and resumes in the first cycle the input is seen low. With flow control disabled, frames run back to back and the input is ignored. An interrupt request is raised either when the buffer hands its word to the shift register or when the whole transmission finishes. It stays raised until acknowledged. Dropping the enable aborts the frame in flight.

Top module: `uart_tx_cts`

## Requirements
- R1: While a frame is active, each bit lasts `OVS × (div_i + 1)` count-source ticks. The bit counter restarts at every frame start.
- R2: `src_sel_i` picks the count source. 0 gives a tick every clock. 1 gives a tick every 8 clocks. 2 gives a tick every `2 × pre_n_i` clocks, or every clock when `pre_n_i` is 0. 3 takes each clock in which `ext_tick_i` is high as a tick. The divider restarts from zero while `tx_en_i` is low.
- R3: A frame is a 0 start bit, then the data bits LSB first (`wr_data_i[7:0]`, plus bit 8 when `nine_bit_i` is 1), then the parity bit when `par_en_i` is 1, then one stop bit of value 1, or two when `two_stop_i` is 1. The format is taken from the inputs in the cycle the word is transferred.
- R4: With `par_odd_i` 0 the parity bit makes the count of ones over data and parity even. With `par_odd_i` 1 it makes that count odd.
- R5: A write sets `buf_empty_o` to 0 one clock later. The word is transferred when the shifter is idle, `tx_en_i` is 1 and flow control allows it, and `buf_empty_o` returns to 1 after that clock edge. A write in the transfer cycle refills the buffer. Consecutive frames are separated by one idle clock.
- R6: `tx_empty_o` is 1 only when both the shifter and the buffer are empty. It rises only when a frame ends or is aborted.
- R7: With `cts_en_i` 1, no frame starts while `cts_i` is 1. The waiting word starts in the first clock that `cts_i` is sampled 0. A frame already started always completes.
- R8: With `cts_en_i` 0, `cts_i` has no effect on when frames start.
- R9: With `irq_src_i` 0, `irq_o` is set by each transfer from buffer to shifter. With `irq_src_i` 1, it is set when the last stop bit ends while the buffer is empty and no write occurs in that clock.
- R10: `irq_o` stays 1 until a clock with `irq_ack_i` 1. A set event in the same clock wins over the acknowledge.
- R11: With `tx_en_i` 0, any frame is aborted and `txd_o` is 1 from the next clock. Writes are still accepted and held until the block is enabled again.
- R12: After reset, `txd_o` = 1, `buf_empty_o` = 1, `tx_empty_o` = 1 and `irq_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable |
| src_sel_i | input | 2 | Count source select (0 clk, 1 /8, 2 /2n, 3 external) |
| pre_n_i | input | PRE_W | n for the divide-by-2n source |
| div_i | input | DIV_W | Bit-rate divisor m |
| ext_tick_i | input | 1 | External count-source tick, one clock wide |
| nine_bit_i | input | 1 | 1 selects 9 data bits |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 selects odd parity |
| two_stop_i | input | 1 | 1 selects two stop bits |
| cts_en_i | input | 1 | Flow-control enable |
| cts_i | input | 1 | Clear-to-send, active low |
| irq_src_i | input | 1 | Interrupt source: 0 transfer, 1 completion |
| wr_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 9 | Data word |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| txd_o | output | 1 | Serial output |
| buf_empty_o | output | 1 | Buffer empty flag |
| tx_empty_o | output | 1 | Buffer and shifter both empty |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with `OVS = 4` and `DIV_W = 4`. This keeps a 13-bit frame within a few hundred clocks even on the divide-by-8 and divide-by-2n sources, so every source selection, a non-zero divisor and both frame extremes fit in one short run. The small oversampling factor still leaves bit periods long enough to sample in mid-bit. It also keeps back-to-back transfers, flow-control stalls and mid-frame aborts a few cycles apart, where the one-clock inter-frame gap and the transfer-cycle write are exposed.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    SRC_CLK   = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV2N = 2'd2,
    SRC_EXT   = 2'd3
  } src_sel_e;

  localparam int unsigned MAX_DATA = 9;
  localparam int unsigned FRAME_W  = 1 + MAX_DATA + 1 + 2;
  localparam int unsigned LEN_W    = $clog2(FRAME_W + 1);

  function automatic logic par_calc(logic [MAX_DATA-1:0] d, logic nine, logic odd);
    logic p;
    p = ^d[7:0];
    if (nine) p = p ^ d[8];
    return p ^ odd;
  endfunction
endpackage

// File: rtl/uart_tx_prescale.sv
module uart_tx_prescale import uart_tx_pkg::*; #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  src_sel_e         sel_i,
  input  logic [PRE_W-1:0] pre_n_i,
  input  logic             ext_tick_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (PRE_W + 1 > 3) ? PRE_W + 1 : 3;

  logic [CNT_W-1:0] cnt_q, lim;
  logic             divided;

  assign lim = CNT_W'({pre_n_i, 1'b0}) - CNT_W'(1);

  always_comb begin
    tick_o  = 1'b0;
    divided = 1'b0;
    case (sel_i)
      SRC_CLK:   tick_o = 1'b1;
      SRC_DIV8: begin
        divided = 1'b1;
        tick_o  = (cnt_q == CNT_W'(7));
      end
      SRC_DIV2N: begin
        divided = (pre_n_i != '0);
        tick_o  = !divided || (cnt_q == lim);
      end
      SRC_EXT:   tick_o = ext_tick_i;
      default:   tick_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !divided) cnt_q <= '0;
    else if (tick_o)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);
  localparam int unsigned CNT_W = DIV_W + $clog2(OVS) + 1;

  logic [CNT_W-1:0] cnt_q, last;

  assign last      = CNT_W'(OVS) * (CNT_W'(div_i) + CNT_W'(1)) - CNT_W'(1);
  assign bit_end_o = run_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (bit_end_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter import uart_tx_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               bit_end_i,
  output logic               busy_o,
  output logic               txd_o,
  output logic               done_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   left_q;
  logic               busy_q;

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign done_o = busy_q && bit_end_i && (left_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      sh_q   <= frame_i;
      left_q <= len_i;
    end else if (busy_q && bit_end_i) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - LEN_W'(1);
      if (left_q == LEN_W'(1)) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts import uart_tx_pkg::*; #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PRE_W = 4,
  parameter int unsigned OVS   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_en_i,
  input  logic [1:0]          src_sel_i,
  input  logic [PRE_W-1:0]    pre_n_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                ext_tick_i,
  input  logic                nine_bit_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                two_stop_i,
  input  logic                cts_en_i,
  input  logic                cts_i,
  input  logic                irq_src_i,
  input  logic                wr_i,
  input  logic [MAX_DATA-1:0] wr_data_i,
  input  logic                irq_ack_i,
  output logic                txd_o,
  output logic                buf_empty_o,
  output logic                tx_empty_o,
  output logic                irq_o
);
  logic                buf_full_q;
  logic [MAX_DATA-1:0] buf_q;
  logic                irq_q;
  logic                src_tick, bit_end, busy, done, load, cts_ok, irq_set;
  logic [FRAME_W-1:0]  frame;
  logic [LEN_W-1:0]    len;

  assign cts_ok = !cts_en_i || !cts_i;
  assign load   = tx_en_i && !busy && buf_full_q && cts_ok;

  // frame image, LSB leaves first; unused upper bits stay 1 (stop level)
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < int'(MAX_DATA); i++) begin
      if (i < 8 || nine_bit_i) frame[1+i] = buf_q[i];
    end
    if (par_en_i) begin
      if (nine_bit_i) frame[10] = par_calc(buf_q, 1'b1, par_odd_i);
      else            frame[9]  = par_calc(buf_q, 1'b0, par_odd_i);
    end
    len = LEN_W'(9) + LEN_W'(nine_bit_i) + LEN_W'(par_en_i) + LEN_W'(two_stop_i) + LEN_W'(1);
  end

  uart_tx_prescale #(.PRE_W(PRE_W)) i_prescale (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tx_en_i),
    .sel_i      (src_sel_e'(src_sel_i)),
    .pre_n_i    (pre_n_i),
    .ext_tick_i (ext_tick_i),
    .tick_o     (src_tick)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OVS(OVS)) i_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy && tx_en_i),
    .tick_i    (src_tick),
    .div_i     (div_i),
    .bit_end_o (bit_end)
  );

  uart_tx_shifter i_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tx_en_i),
    .load_i    (load),
    .frame_i   (frame),
    .len_i     (len),
    .bit_end_i (bit_end),
    .busy_o    (busy),
    .txd_o     (txd_o),
    .done_o    (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
    end else if (wr_i) begin
      buf_full_q <= 1'b1;
      buf_q      <= wr_data_i;
    end else if (load) begin
      buf_full_q <= 1'b0;
    end
  end

  assign irq_set = irq_src_i ? (done && !buf_full_q && !wr_i) : load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_ack_i) irq_q <= 1'b0;
  end

  assign irq_o       = irq_q;
  assign buf_empty_o = !buf_full_q;
  assign tx_empty_o  = !busy && !buf_full_q;
endmodule

// File: rtl/uart_tx_cts_chk.sv
module uart_tx_cts_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic wr_i,
  input logic irq_ack_i,
  input logic cts_en_i,
  input logic cts_i,
  input logic busy,
  input logic txd_o,
  input logic buf_empty_o,
  input logic tx_empty_o,
  input logic irq_o
);
  // R11
  txd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> txd_o);

  // R5
  wr_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !buf_empty_o);

  // R6
  empty_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(busy));

  // R7
  cts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_en_i && cts_i && !busy) |=> !busy);

  // R10
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);
endmodule

bind uart_tx_cts uart_tx_cts_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .wr_i        (wr_i),
  .irq_ack_i   (irq_ack_i),
  .cts_en_i    (cts_en_i),
  .cts_i       (cts_i),
  .busy        (busy),
  .txd_o       (txd_o),
  .buf_empty_o (buf_empty_o),
  .tx_empty_o  (tx_empty_o),
  .irq_o       (irq_o)
);

// File: tb/test_uart_tx_cts.sv
module test_uart_tx_cts;
  localparam int DIV_W = 4;
  localparam int PRE_W = 4;
  localparam int OVS   = 4;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             tx_en, ext_tick, nine, par_en, par_odd, two, cts_en, cts, irq_src, wr, ack;
  logic [1:0]       sel;
  logic [PRE_W-1:0] pre_n;
  logic [DIV_W-1:0] div;
  logic [8:0]       wd;
  logic             txd, buf_empty, tx_empty, irq;
  logic             ext_on;

  uart_tx_cts #(.DIV_W(DIV_W), .PRE_W(PRE_W), .OVS(OVS)) i_uart_tx_cts (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .src_sel_i(sel), .pre_n_i(pre_n),
    .div_i(div), .ext_tick_i(ext_tick), .nine_bit_i(nine), .par_en_i(par_en),
    .par_odd_i(par_odd), .two_stop_i(two), .cts_en_i(cts_en), .cts_i(cts),
    .irq_src_i(irq_src), .wr_i(wr), .wr_data_i(wd), .irq_ack_i(ack),
    .txd_o(txd), .buf_empty_o(buf_empty), .tx_empty_o(tx_empty), .irq_o(irq)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // external count source: one tick every third clock
  always @(negedge clk) ext_tick = ext_on && (cyc % 3 == 0);

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  // ---------------- behavioural reference model ----------------
  int       m_pre, m_bc;
  bit       m_busy, m_full, m_irq;
  bit [8:0] m_buf;
  bit       m_q[$];
  bit       md_tick, md_load, md_done, md_div;
  int       md_ones;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_bc = 0; m_busy = 0; m_full = 0; m_irq = 0; m_buf = '0;
      m_q.delete();
    end else begin
      md_div = 0;
      case (sel)
        2'd0: md_tick = 1;
        2'd1: begin md_tick = (m_pre == 7); md_div = 1; end
        2'd2: begin
          md_tick = (pre_n == 0) || (m_pre == 2 * int'(pre_n) - 1);
          md_div  = (pre_n != 0);
        end
        default: md_tick = ext_tick;
      endcase
      md_load = tx_en && !m_busy && m_full && (!cts_en || !cts);
      md_done = 0;
      if (!tx_en || !md_div || md_tick) m_pre = 0; else m_pre++;
      if (!tx_en) begin
        m_busy = 0; m_bc = 0; m_q.delete();
      end else if (md_load) begin
        m_q.delete();
        m_q.push_back(1'b0);
        md_ones = 0;
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
          m_q.push_back(m_buf[i]);
          md_ones += int'(m_buf[i]);
        end
        if (par_en) m_q.push_back(par_odd ? (md_ones % 2 == 0) : (md_ones % 2 == 1));
        m_q.push_back(1'b1);
        if (two) m_q.push_back(1'b1);
        m_busy = 1; m_bc = 0;
      end else if (m_busy && md_tick) begin
        if (m_bc == OVS * (int'(div) + 1) - 1) begin
          m_bc = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin m_busy = 0; md_done = 1; end
        end else m_bc++;
      end
      if (irq_src ? (md_done && !m_full && !wr) : md_load) m_irq = 1;
      else if (ack) m_irq = 0;
      if (wr) begin m_full = 1; m_buf = wd; end
      else if (md_load) m_full = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(txd == (m_busy ? m_q[0] : 1'b1), "R3/R1 model txd", int'(txd), int'(m_busy ? m_q[0] : 1'b1));
      chk(buf_empty == !m_full, "R5 model buf_empty", int'(buf_empty), int'(!m_full));
      chk(tx_empty == (!m_busy && !m_full), "R6 model tx_empty", int'(tx_empty), int'(!m_busy && !m_full));
      chk(irq == m_irq, "R9/R10 model irq", int'(irq), int'(m_irq));
    end
  end

  // ---------------- directed helpers ----------------
  task automatic write_word(input logic [8:0] d);
    wr = 1'b1; wd = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_start(input string tag, input int limit);
    int n = 0;
    while (txd !== 1'b0 && n < limit) begin @(negedge clk); n++; end
    chk(txd === 1'b0, tag, n, limit);
  endtask

  task automatic wait_idle(input int limit);
    int n = 0;
    while (tx_empty !== 1'b1 && n < limit) begin @(negedge clk); n++; end
  endtask

  // entry: 'pre' negedges after the one half a clock past the start edge
  task automatic check_frame(input logic [8:0] d, input bit nb9, input bit pe, input bit po,
                             input bit st2, input int per, input int pre, input string tag);
    bit exp_b[$];
    int ones = 0;
    exp_b.push_back(1'b0);
    for (int i = 0; i < (nb9 ? 9 : 8); i++) begin exp_b.push_back(d[i]); ones += int'(d[i]); end
    if (pe) exp_b.push_back(po ? (ones % 2 == 0) : (ones % 2 == 1));
    exp_b.push_back(1'b1);
    if (st2) exp_b.push_back(1'b1);
    repeat (per / 2 - pre) @(negedge clk);
    for (int k = 0; k < exp_b.size(); k++) begin
      if (k > 0) repeat (per) @(negedge clk);
      chk(txd == exp_b[k], $sformatf("%s bit%0d", tag, k), int'(txd), int'(exp_b[k]));
    end
  endtask

  initial begin
    tx_en = 0; sel = 0; pre_n = 0; div = 0; nine = 0; par_en = 0; par_odd = 0; two = 0;
    cts_en = 0; cts = 0; irq_src = 0; wr = 0; wd = 0; ack = 0; ext_on = 0; ext_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(txd == 1'b1, "R12 txd", int'(txd), 1);
    chk(buf_empty == 1'b1, "R12 buf_empty", int'(buf_empty), 1);
    chk(tx_empty == 1'b1, "R12 tx_empty", int'(tx_empty), 1);
    chk(irq == 1'b0, "R12 irq", int'(irq), 0);
    tx_en = 1'b1;
    @(negedge clk);

    // A: 8 bits, no parity, 1 stop, clk source, m=0 (R1 R3 R5 R6 R9)
    write_word(9'h0A5);
    chk(buf_empty == 1'b0, "R5 write clears empty", int'(buf_empty), 0);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R5 transfer sets empty", int'(buf_empty), 1);
    chk(tx_empty == 1'b0, "R6 busy not empty", int'(tx_empty), 0);
    chk(irq == 1'b1, "R9 irq on transfer", int'(irq), 1);
    check_frame(9'h0A5, 0, 0, 0, 0, OVS, 0, "R3 A");
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(irq == 1'b0, "R10 ack clears", int'(irq), 0);
    wait_idle(200);
    chk(tx_empty == 1'b1, "R6 idle", int'(tx_empty), 1);

    // B: 9 bits, even parity, 2 stops, m=1, back-to-back (R1 R4 R5)
    nine = 1; par_en = 1; two = 1; div = 1;
    write_word(9'h1C3);
    @(negedge clk);
    write_word(9'h02C);
    chk(buf_empty == 1'b0, "R5 second word queued", int'(buf_empty), 0);
    chk(tx_empty == 1'b0, "R6 both full", int'(tx_empty), 0);
    check_frame(9'h1C3, 1, 1, 0, 1, OVS * 2, 1, "R4 B1");
    wait_start("R5 second start", 40);
    check_frame(9'h02C, 1, 1, 0, 1, OVS * 2, 0, "R4 B2");
    wait_idle(400);

    // C: div-by-8 source, odd parity, 8 bits (R2 R4)
    nine = 0; two = 0; par_odd = 1; div = 0; sel = 2'd1;
    write_word(9'h03D);
    wait_start("R2 div8 start", 20);
    check_frame(9'h03D, 0, 1, 1, 0, OVS * 8, 0, "R2 div8");
    wait_idle(2000);

    // D: divide-by-2n source n=3, then n=0 (R2)
    par_en = 0; sel = 2'd2; pre_n = 3;
    write_word(9'h081);
    wait_start("R2 div2n start", 20);
    check_frame(9'h081, 0, 0, 0, 0, OVS * 6, 0, "R2 div2n");
    wait_idle(2000);
    pre_n = 0;
    write_word(9'h07E);
    wait_start("R2 n0 start", 20);
    check_frame(9'h07E, 0, 0, 0, 0, OVS, 0, "R2 n0");
    wait_idle(400);

    // E: external ticks every 3 clocks (R2)
    sel = 2'd3; ext_on = 1;
    write_word(9'h055);
    wait_start("R2 ext start", 20);
    check_frame(9'h055, 0, 0, 0, 0, OVS * 3, 0, "R2 ext");
    wait_idle(2000);
    ext_on = 0; sel = 2'd0;

    // F: flow control enabled (R7)
    cts_en = 1; cts = 1;
    write_word(9'h012);
    repeat (50) @(negedge clk);
    chk(txd == 1'b1, "R7 held by cts", int'(txd), 1);
    chk(buf_empty == 1'b0, "R7 word kept", int'(buf_empty), 0);
    cts = 0;
    @(negedge clk);
    chk(txd == 1'b0, "R7 start on cts low", int'(txd), 0);
    cts = 1;
    check_frame(9'h012, 0, 0, 0, 0, OVS, 1, "R7 frame completes");
    write_word(9'h0F1);
    repeat (40) @(negedge clk);
    chk(tx_empty == 1'b0 && txd == 1'b1, "R7 next frame paused", int'(txd), 1);
    cts = 0;
    wait_start("R7 resume", 5);
    check_frame(9'h0F1, 0, 0, 0, 0, OVS, 0, "R7 resumed frame");
    wait_idle(200);

    // G: flow control disabled, cts high ignored (R8)
    cts_en = 0; cts = 1;
    write_word(9'h0C3);
    @(negedge clk);
    chk(txd == 1'b0, "R8 starts despite cts", int'(txd), 0);
    check_frame(9'h0C3, 0, 0, 0, 0, OVS, 0, "R8 frame");
    wait_idle(200);
    cts = 0;

    // H: completion interrupt (R9 R10)
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    irq_src = 1;
    write_word(9'h0F0);
    @(negedge clk);
    chk(irq == 1'b0, "R9 no irq on transfer", int'(irq), 0);
    wait_idle(200);
    chk(irq == 1'b1, "R9 irq on completion", int'(irq), 1);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R10 irq held", int'(irq), 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk(irq == 1'b0, "R10 irq acked", int'(irq), 0);
    irq_src = 0;

    // I: abort by enable (R11)
    write_word(9'h000);
    wait_start("R11 start", 10);
    repeat (OVS * 3) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R11 abort idles line", int'(txd), 1);
    write_word(9'h1A7);
    repeat (20) @(negedge clk);
    chk(txd == 1'b1, "R11 disabled stays idle", int'(txd), 1);
    chk(buf_empty == 1'b0, "R11 write kept while disabled", int'(buf_empty), 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R11 restart on enable", int'(txd), 0);
    check_frame(9'h1A7, 0, 0, 0, 0, OVS, 0, "R11 frame after enable");
    wait_idle(200);
    repeat (5) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule